// File: doc/BRIEF.md
# Element-Serial Vector Arithmetic Unit

This block is a compact vector execution engine. It keeps a bank of vector registers plus a vector-length register. It runs one integer vector instruction at a time. An accepted instruction is expanded into one element operation per clock. Each element operation reads both source elements from the bank, passes through a three-stage arithmetic pipeline and writes its result back into the destination register. The element count is the current vector length. Four operations exist: add and multiply, each in a vector-with-vector form and a scalar-broadcast form.

A host hands over commands on a valid/ready port. A command is either an arithmetic instruction or a vector-length update. Ready stays low while an instruction is in flight, and a one-cycle completion pulse marks the final write-back. A combinational test read port exposes any element of the bank, so software models and benches can inspect results without disturbing execution.

Top module: `vec_exec_unit`

## Requirements
- R1: After reset, cmd_ready is 1, busy and done are 0, every element of every register reads 0, and the vector length equals VLEN.
- R2: Opcode 00 (with cmd_setvl 0) computes Vd[i] = Va[i] + Vb[i] modulo 2^EW for every i below the vector length.
- R3: Opcode 01 computes Vd[i] = s + Vb[i] modulo 2^EW, with s taken from cmd_scalar and broadcast to every element.
- R4: Opcode 10 computes Vd[i] = low EW bits of Va[i] × Vb[i].
- R5: Opcode 11 computes Vd[i] = low EW bits of s × Vb[i].
- R6: A command with cmd_setvl 1 sets the vector length from cmd_scalar, clamped to 1 when the value is 0 and to VLEN when it exceeds VLEN; it completes in its acceptance cycle with no busy period.
- R7: Destination elements at index greater than or equal to the vector length keep their previous value.
- R8: From the accepting clock edge, cmd_ready stays 0 and done stays 0 until done rises, which happens exactly VL+3 clock edges after that accepting edge; done lasts one cycle and cmd_ready is 1 in that same cycle.
- R9: The element issued at index i is written on the third clock edge after the edge that ends its issue cycle.
- R10: An instruction whose destination equals one or both sources gives the same result as if all sources were read before any write.
- R11: Commands presented while cmd_ready is 0 are ignored: they change neither the bank nor the vector length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_setvl | input | 1 | 1: command writes the vector length; 0: arithmetic instruction |
| cmd_op | input | 2 | Operation: 00 vector add, 01 scalar add, 10 vector multiply, 11 scalar multiply |
| cmd_vd | input | RW | Destination register |
| cmd_va | input | RW | First vector source |
| cmd_vb | input | RW | Second vector source |
| cmd_scalar | input | EW | Broadcast operand, or requested length for a length command |
| busy | output | 1 | An instruction is issuing or draining |
| done | output | 1 | One-cycle pulse after the last write-back |
| tst_reg | input | RW | Test read register select |
| tst_idx | input | IW | Test read element select |
| tst_data | output | EW | Element selected by the test port |

## Verification
Every cycle, the bound checker watches the write-back lag against issue, keeps issued indices inside the vector length, holds the length inside its legal range, and ties done to a preceding final write and to a single-cycle width. Arithmetic results, masking of the tail, the clamp on length updates, in-place correctness and the rejection of commands while busy can only be shown by the bench, which replays each instruction on a reference model of the bank and compares every element through the test port.

// File: rtl/vec_pkg.sv
package vec_pkg;

    typedef enum logic [1:0] {
        OP_ADDV  = 2'b00,
        OP_ADDSV = 2'b01,
        OP_MULTV = 2'b10,
        OP_MULSV = 2'b11
    } vop_e;

    localparam int unsigned PIPE_LAT = 3;

endpackage

// File: rtl/vec_regfile.sv
module vec_regfile #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned VLEN     = 64,
    parameter int unsigned EW       = 64,
    localparam int unsigned RW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned IW      = (VLEN > 1) ? $clog2(VLEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ra_reg,
    input  logic [IW-1:0] ra_idx,
    output logic [EW-1:0] ra_data,
    input  logic [RW-1:0] rb_reg,
    input  logic [IW-1:0] rb_idx,
    output logic [EW-1:0] rb_data,
    input  logic [RW-1:0] rt_reg,
    input  logic [IW-1:0] rt_idx,
    output logic [EW-1:0] rt_data,
    input  logic          we,
    input  logic [RW-1:0] w_reg,
    input  logic [IW-1:0] w_idx,
    input  logic [EW-1:0] w_data
);
    localparam int unsigned DEPTH = NUM_REGS * VLEN;
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [EW-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] loc(input logic [RW-1:0] r, input logic [IW-1:0] i);
        return AW'(r) * AW'(VLEN) + AW'(i);
    endfunction

    // three independent read ports, all combinational
    assign ra_data = mem[loc(ra_reg, ra_idx)];
    assign rb_data = mem[loc(rb_reg, rb_idx)];
    assign rt_data = mem[loc(rt_reg, rt_idx)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            mem[loc(w_reg, w_idx)] <= w_data;
        end
    end
endmodule

// File: rtl/vec_alu_pipe.sv
module vec_alu_pipe #(
    parameter int unsigned EW = 64,
    parameter int unsigned RW = 3,
    parameter int unsigned IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic          in_mul,
    input  logic [EW-1:0] in_a,
    input  logic [EW-1:0] in_b,
    input  logic [RW-1:0] in_vd,
    input  logic [IW-1:0] in_idx,
    output logic          out_valid,
    output logic          out_last,
    output logic [RW-1:0] out_vd,
    output logic [IW-1:0] out_idx,
    output logic [EW-1:0] out_data,
    output logic          busy
);
    typedef struct packed {
        logic          v;
        logic          last;
        logic          mul;
        logic [EW-1:0] a;
        logic [EW-1:0] b;
        logic [RW-1:0] vd;
        logic [IW-1:0] idx;
    } opnd_t;

    typedef struct packed {
        logic          v;
        logic          last;
        logic [EW-1:0] res;
        logic [RW-1:0] vd;
        logic [IW-1:0] idx;
    } rslt_t;

    typedef struct packed {
        opnd_t s1;
        rslt_t s2;
        rslt_t s3;
    } pipe_t;

    pipe_t d, q;

    always_comb begin
        d = q;
        // stage 1: capture operands
        d.s1.v    = in_valid;
        d.s1.last = in_last;
        d.s1.mul  = in_mul;
        d.s1.a    = in_a;
        d.s1.b    = in_b;
        d.s1.vd   = in_vd;
        d.s1.idx  = in_idx;
        // stage 2: arithmetic, modulo 2^EW
        d.s2.v    = q.s1.v;
        d.s2.last = q.s1.last;
        d.s2.res  = q.s1.mul ? (q.s1.a * q.s1.b) : (q.s1.a + q.s1.b);
        d.s2.vd   = q.s1.vd;
        d.s2.idx  = q.s1.idx;
        // stage 3: result register driving write-back
        d.s3      = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.s3.v;
    assign out_last  = q.s3.v & q.s3.last;
    assign out_vd    = q.s3.vd;
    assign out_idx   = q.s3.idx;
    assign out_data  = q.s3.res;
    assign busy      = q.s1.v | q.s2.v | q.s3.v;
endmodule

// File: rtl/vec_seq.sv
module vec_seq import vec_pkg::*; #(
    parameter int unsigned VLEN = 64,
    parameter int unsigned EW   = 64,
    parameter int unsigned RW   = 3,
    parameter int unsigned IW   = 6,
    parameter int unsigned LW   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_setvl,
    input  logic [1:0]    cmd_op,
    input  logic [RW-1:0] cmd_vd,
    input  logic [RW-1:0] cmd_va,
    input  logic [RW-1:0] cmd_vb,
    input  logic [EW-1:0] cmd_scalar,
    input  logic          pipe_busy,
    input  logic          wr_last,
    output logic          busy,
    output logic          done,
    output logic          iss_valid,
    output logic          iss_last,
    output logic [IW-1:0] iss_idx,
    output vop_e          iss_op,
    output logic [RW-1:0] iss_vd,
    output logic [RW-1:0] iss_va,
    output logic [RW-1:0] iss_vb,
    output logic [EW-1:0] iss_scalar,
    output logic [LW-1:0] vl
);
    typedef struct packed {
        logic          run;
        logic [IW-1:0] idx;
        logic [LW-1:0] vl;
        vop_e          op;
        logic [RW-1:0] vd;
        logic [RW-1:0] va;
        logic [RW-1:0] vb;
        logic [EW-1:0] scalar;
        logic          done;
    } seq_t;

    seq_t d, q;
    logic at_end;
    logic [LW-1:0] vl_req;

    assign at_end = (LW'(q.idx) + LW'(1)) == q.vl;

    always_comb begin
        if (cmd_scalar == '0)              vl_req = LW'(1);
        else if (cmd_scalar > EW'(VLEN))   vl_req = LW'(VLEN);
        else                               vl_req = cmd_scalar[LW-1:0];
    end

    always_comb begin
        d      = q;
        d.done = wr_last;
        if (q.run) begin
            if (at_end) d.run = 1'b0;
            else        d.idx = q.idx + IW'(1);
        end else if (cmd_valid && cmd_ready) begin
            if (cmd_setvl) begin
                d.vl = vl_req;
            end else begin
                d.run    = 1'b1;
                d.idx    = '0;
                d.op     = vop_e'(cmd_op);
                d.vd     = cmd_vd;
                d.va     = cmd_va;
                d.vb     = cmd_vb;
                d.scalar = cmd_scalar;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.vl <= LW'(VLEN);
        end else begin
            q <= d;
        end
    end

    assign cmd_ready  = !q.run && !pipe_busy;
    assign busy       = q.run || pipe_busy;
    assign done       = q.done;
    assign iss_valid  = q.run;
    assign iss_last   = at_end;
    assign iss_idx    = q.idx;
    assign iss_op     = q.op;
    assign iss_vd     = q.vd;
    assign iss_va     = q.va;
    assign iss_vb     = q.vb;
    assign iss_scalar = q.scalar;
    assign vl         = q.vl;
endmodule

// File: rtl/vec_exec_unit.sv
module vec_exec_unit import vec_pkg::*; #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned VLEN     = 64,
    parameter int unsigned EW       = 64,
    localparam int unsigned RW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned IW      = (VLEN > 1) ? $clog2(VLEN) : 1,
    localparam int unsigned LW      = $clog2(VLEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_setvl,
    input  logic [1:0]    cmd_op,
    input  logic [RW-1:0] cmd_vd,
    input  logic [RW-1:0] cmd_va,
    input  logic [RW-1:0] cmd_vb,
    input  logic [EW-1:0] cmd_scalar,
    output logic          busy,
    output logic          done,
    input  logic [RW-1:0] tst_reg,
    input  logic [IW-1:0] tst_idx,
    output logic [EW-1:0] tst_data
);
    logic          iss_valid, iss_last;
    logic [IW-1:0] iss_idx;
    vop_e          iss_op;
    logic [RW-1:0] iss_vd, iss_va, iss_vb;
    logic [EW-1:0] iss_scalar;
    logic [LW-1:0] vl;
    logic [EW-1:0] rd_a, rd_b, op_a;
    logic          wr_en, wr_last, pipe_busy;
    logic [RW-1:0] wr_vd;
    logic [IW-1:0] wr_idx;
    logic [EW-1:0] wr_data;

    vec_seq #(.VLEN(VLEN), .EW(EW), .RW(RW), .IW(IW), .LW(LW)) i_seq (
        .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_setvl, .cmd_op,
        .cmd_vd, .cmd_va, .cmd_vb, .cmd_scalar,
        .pipe_busy, .wr_last, .busy, .done,
        .iss_valid, .iss_last, .iss_idx, .iss_op,
        .iss_vd, .iss_va, .iss_vb, .iss_scalar, .vl
    );

    vec_regfile #(.NUM_REGS(NUM_REGS), .VLEN(VLEN), .EW(EW)) i_bank (
        .clk, .rst_n,
        .ra_reg(iss_va), .ra_idx(iss_idx), .ra_data(rd_a),
        .rb_reg(iss_vb), .rb_idx(iss_idx), .rb_data(rd_b),
        .rt_reg(tst_reg), .rt_idx(tst_idx), .rt_data(tst_data),
        .we(wr_en), .w_reg(wr_vd), .w_idx(wr_idx), .w_data(wr_data)
    );

    // scalar forms (op bit 0) broadcast the scalar in place of the first source
    assign op_a = iss_op[0] ? iss_scalar : rd_a;

    vec_alu_pipe #(.EW(EW), .RW(RW), .IW(IW)) i_alu (
        .clk, .rst_n,
        .in_valid(iss_valid), .in_last(iss_last), .in_mul(iss_op[1]),
        .in_a(op_a), .in_b(rd_b), .in_vd(iss_vd), .in_idx(iss_idx),
        .out_valid(wr_en), .out_last(wr_last), .out_vd(wr_vd),
        .out_idx(wr_idx), .out_data(wr_data), .busy(pipe_busy)
    );
endmodule

// File: rtl/vec_exec_unit_chk.sv
module vec_exec_unit_chk #(
    parameter int unsigned VLEN = 64,
    parameter int unsigned IW   = 6,
    parameter int unsigned LW   = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          cmd_setvl,
    input logic          busy,
    input logic          done,
    input logic          iss_valid,
    input logic [IW-1:0] iss_idx,
    input logic [LW-1:0] vl,
    input logic          wr_en,
    input logic          wr_last
);
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_setvl) |=> busy);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_follows_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_last));

    p_wb_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(iss_valid, 3));

    p_issue_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> ##2 wr_en);

    p_idx_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (LW'(iss_idx) < vl));

    p_vl_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vl >= LW'(1)) && (vl <= LW'(VLEN)));
endmodule

bind vec_exec_unit vec_exec_unit_chk #(.VLEN(VLEN), .IW(IW), .LW(LW)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_setvl(cmd_setvl), .busy(busy), .done(done), .iss_valid(iss_valid),
    .iss_idx(iss_idx), .vl(vl), .wr_en(wr_en), .wr_last(wr_last)
);

// File: tb/test_vec_exec_unit.sv
module test_vec_exec_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;
    localparam int VL = 64;
    localparam int EW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_setvl = 1'b0;
    logic          cmd_ready, busy, done;
    logic [1:0]    cmd_op = '0;
    logic [2:0]    cmd_vd = '0, cmd_va = '0, cmd_vb = '0;
    logic [EW-1:0] cmd_scalar = '0;
    logic [2:0]    tst_reg = '0;
    logic [5:0]    tst_idx = '0;
    logic [EW-1:0] tst_data;

    logic [EW-1:0] m [NR][VL];
    int vl_m = VL;
    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    int unsigned seed = 32'd20240611;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_exec_unit i_vec_exec_unit (
        .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_setvl, .cmd_op,
        .cmd_vd, .cmd_va, .cmd_vb, .cmd_scalar, .busy, .done,
        .tst_reg, .tst_idx, .tst_data
    );

    task automatic chk(input bit ok, input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] ref_op(input logic [1:0] op, input logic [EW-1:0] a,
                                             input logic [EW-1:0] b, input logic [EW-1:0] s);
        logic [EW-1:0] x;
        x = op[0] ? s : a;
        return op[1] ? (x * b) : (x + b);
    endfunction

    task automatic check_bank(input string tag);
        for (int r = 0; r < NR; r++) begin
            logic [EW-1:0] fa, fe;
            bit ok;
            ok = 1; fa = '0; fe = '0;
            for (int i = 0; i < VL; i++) begin
                tst_reg = 3'(r); tst_idx = 6'(i);
                #1;
                if (ok && tst_data !== m[r][i]) begin
                    ok = 0; fa = tst_data; fe = m[r][i];
                end
            end
            chk(ok, $sformatf("%s bank reg %0d", tag, r), fa, fe);
        end
        @(negedge clk);
    endtask

    task automatic set_vl(input logic [EW-1:0] v);
        @(negedge clk);
        cmd_valid = 1; cmd_setvl = 1; cmd_scalar = v;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0; cmd_setvl = 0;
        chk(!busy && cmd_ready, "R6 no busy after length update", {63'd0, busy}, 64'd0);
        if (v == 0) vl_m = 1;
        else if (v > VL) vl_m = VL;
        else vl_m = int'(v);
    endtask

    task automatic run_vec(input logic [1:0] op, input int vd, input int va, input int vb,
                           input logic [EW-1:0] s, input string tag, input bit inject);
        int n;
        bit seen, rdy_bad;
        @(negedge clk);
        cmd_valid = 1; cmd_setvl = 0; cmd_op = op;
        cmd_vd = 3'(vd); cmd_va = 3'(va); cmd_vb = 3'(vb); cmd_scalar = s;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        n = 0; seen = 0; rdy_bad = 0;
        while (!seen && n < VL + 20) begin
            @(negedge clk);
            if (inject && n < 2) begin
                cmd_valid = 1; cmd_setvl = 1; cmd_scalar = 64'd5;
                cmd_op = 2'b01; cmd_vd = 3'(vb);
            end else begin
                cmd_valid = 0; cmd_setvl = 0;
            end
            if (done) seen = 1;
            else begin
                if (cmd_ready || done) rdy_bad = 1;
                @(posedge clk);
                n++;
            end
        end
        chk(seen && n == vl_m + 3, $sformatf("R8 R9 %s done edge count", tag), 64'(n), 64'(vl_m + 3));
        chk(!rdy_bad && cmd_ready, $sformatf("R8 %s ready low until done", tag), {63'd0, rdy_bad}, 64'd0);
        begin
            logic [EW-1:0] tmp [VL];
            for (int i = 0; i < vl_m; i++) tmp[i] = ref_op(op, m[va][i], m[vb][i], s);
            for (int i = 0; i < vl_m; i++) m[vd][i] = tmp[i];
        end
        check_bank(tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(seed));
        for (int r = 0; r < NR; r++)
            for (int i = 0; i < VL; i++) m[r][i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(cmd_ready && !busy && !done, "R1 reset handshake state",
            {61'd0, cmd_ready, busy, done}, 64'd4);
        check_bank("R1");
        // R1 + R3: default length covers every element
        run_vec(2'b01, 0, 0, 0, 64'h0123_4567_89ab_cdef, "R1 R3 default length", 0);
        // R6 + R7: zero length clamps to one element
        set_vl(64'd0);
        run_vec(2'b01, 1, 0, 1, 64'd77, "R6 R7 clamp low", 0);
        // R6: oversize clamps to VLEN; R2 vector add
        set_vl(64'd200);
        run_vec(2'b00, 2, 0, 1, 64'd0, "R6 R2 clamp high", 0);
        // seed registers with partial lengths (R3, R7)
        for (int r = 0; r < NR; r++) begin
            set_vl(64'(r * 9 + 5));
            run_vec(2'b01, r, 0, r, {$urandom, $urandom}, "R3 R7 partial", 0);
        end
        set_vl(64'd64);
        run_vec(2'b10, 3, 0, 1, 64'd0, "R4 multiply", 0);
        run_vec(2'b11, 4, 0, 2, 64'hffff_ffff_ffff_fffd, "R5 scalar multiply", 0);
        // R10: in-place forms
        set_vl(64'd37);
        run_vec(2'b10, 5, 5, 5, 64'd0, "R10 in-place multiply", 0);
        run_vec(2'b00, 6, 6, 3, 64'd0, "R10 in-place add", 0);
        // R11: commands while busy are dropped; following run uses unchanged length
        run_vec(2'b00, 7, 1, 2, 64'd0, "R11 busy inject", 1);
        run_vec(2'b01, 7, 0, 7, 64'd9, "R11 length unchanged", 0);
        // random mix
        for (int k = 0; k < 40; k++) begin
            if ($urandom_range(0, 2) == 0) set_vl(64'($urandom_range(0, 70)));
            run_vec(2'($urandom_range(0, 3)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                    int'($urandom_range(0, 7)), {$urandom, $urandom}, "R2 R3 R4 R5 random", 0);
        end
        set_vl(64'd64);
        run_vec(2'b11, 0, 0, 7, 64'd1, "R5 R7 full boundary", 0);
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule